// File: doc/BRIEF.md
# Fixed-Framing Line-Coding Clamp

This block sits in front of a serial engine that can only run with eight data bits, no parity and one stop bit. Line-coding requests arrive over a valid/ready interface. Each request carries a baud value and three framing fields. The block copies the baud value to its output unchanged and replaces the framing with the one combination the engine supports. The request then leaves through a single output register with its own valid/ready handshake.

A request that had to be rewritten counts as a divergence. Every divergence increments a saturating counter that can be read at a port. The first divergence after reset also raises a single-cycle warning pulse, which a bring-up monitor can latch.

Top module: `linecode_clamp`

## Requirements
- R1: The baud value of every accepted request appears unchanged on `out_baud` when that request is presented at the output.
- R2: Every output request carries `out_dbits`=8, `out_stop`=0 and `out_parity`=0. The field encodings are: `dbits` holds the number of data bits; `stop` uses 0 for one stop bit, 1 for one and a half and 2 for two; `parity` uses 0 for none, 1 for odd, 2 for even, 3 for mark and 4 for space.
- R3: An accepted request is altered when any of its fields differs from dbits=8, stop=0 or parity=0. Each altered request raises `clamp_count` by exactly one in the cycle after it is accepted.
- R4: An accepted request that is already dbits=8, stop=0, parity=0 leaves `clamp_count` unchanged and raises no warning.
- R5: `warn_pulse` is high for exactly one cycle: the cycle after the first altered request since reset is accepted. No later altered request raises it again until the next reset.
- R6: `clamp_count` stops at 2^CNT_W-1 and does not wrap.
- R7: A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. `out_valid` is high in the cycle after an acceptance.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output request holds its value.
- R9: During and right after reset, `out_valid`, `warn_pulse` and `clamp_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken |
| in_baud | input | BAUD_W | Requested baud value |
| in_dbits | input | 4 | Requested data bits |
| in_stop | input | 2 | Requested stop-bit code |
| in_parity | input | 3 | Requested parity code |
| out_valid | output | 1 | Clamped request available |
| out_ready | input | 1 | Engine takes the request |
| out_baud | output | BAUD_W | Forwarded baud value |
| out_dbits | output | 4 | Clamped data bits |
| out_stop | output | 2 | Clamped stop-bit code |
| out_parity | output | 3 | Clamped parity code |
| warn_pulse | output | 1 | First-divergence warning |
| clamp_count | output | CNT_W | Saturating divergence count |

## Verification
The bench sweeps every value of the three framing fields with a narrow counter, so the counter reaches its ceiling early in the run. A design that wraps would then show small counts again, and one that treats only some fields as divergent would fall behind the expected count. A canonical request is sent both first after reset and mid-sweep. A design that flags it would raise the warning or bump the count too soon. A second reset followed by two altered requests shows whether the warning re-arms and stays single, and a stalled output with a competing request pending shows whether a held request is overwritten.

// File: rtl/fclamp_pkg.sv
package fclamp_pkg;
   localparam int DB_W  = 4;
   localparam int SB_W  = 2;
   localparam int PAR_W = 3;

   typedef enum logic [SB_W-1:0] {
      STOP_ONE  = 2'd0,
      STOP_HALF = 2'd1,
      STOP_TWO  = 2'd2
   } stop_e;

   typedef enum logic [PAR_W-1:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_MARK  = 3'd3,
      PAR_SPACE = 3'd4
   } par_e;

   typedef struct packed {
      logic [DB_W-1:0]  dbits;
      logic [SB_W-1:0]  stop;
      logic [PAR_W-1:0] parity;
   } frame_t;

   localparam logic [DB_W-1:0] CANON_DBITS = 4'd8;
   localparam frame_t CANON_FRAME = '{dbits: CANON_DBITS,
                                      stop: STOP_ONE,
                                      parity: PAR_NONE};
endpackage

// File: rtl/fclamp_detect.sv
module fclamp_detect
   import fclamp_pkg::*;
(
   input  frame_t req_frame,
   output frame_t clamped_frame,
   output logic   altered
);
   localparam int NFIELD = 3;
   logic [NFIELD-1:0] mismatch;

   // one mismatch bit per framing field
   for (genvar f = 0; f < NFIELD; f++) begin : g_field
      if (f == 0) begin : g_db
         assign mismatch[f] = (req_frame.dbits != CANON_FRAME.dbits);
      end else if (f == 1) begin : g_sb
         assign mismatch[f] = (req_frame.stop != CANON_FRAME.stop);
      end else begin : g_par
         assign mismatch[f] = (req_frame.parity != CANON_FRAME.parity);
      end
   end

   assign altered = |mismatch;

   always_comb begin
      clamped_frame = req_frame;
      if (altered) clamped_frame = CANON_FRAME;
   end
endmodule

// File: rtl/fclamp_slice.sv
module fclamp_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [W-1:0] s_data,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [W-1:0] m_data
);
   assign s_ready = !m_valid || m_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_data  <= '0;
      end else if (s_ready) begin
         m_valid <= s_valid;
         if (s_valid) m_data <= s_data;
      end
   end
endmodule

// File: rtl/fclamp_tally.sv
module fclamp_tally #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   output logic [CNT_W-1:0] count,
   output logic             warn
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic warned;
   logic at_max;

   assign at_max = (count == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         warned <= 1'b0;
         warn   <= 1'b0;
      end else begin
         warn <= hit && !warned;
         if (hit) warned <= 1'b1;
         if (hit && !at_max) count <= count + CNT_ONE;
      end
   end
endmodule

// File: rtl/linecode_clamp.sv
module linecode_clamp
   import fclamp_pkg::*;
#(
   parameter int BAUD_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BAUD_W-1:0] in_baud,
   input  logic [DB_W-1:0]   in_dbits,
   input  logic [SB_W-1:0]   in_stop,
   input  logic [PAR_W-1:0]  in_parity,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BAUD_W-1:0] out_baud,
   output logic [DB_W-1:0]   out_dbits,
   output logic [SB_W-1:0]   out_stop,
   output logic [PAR_W-1:0]  out_parity,
   output logic              warn_pulse,
   output logic [CNT_W-1:0]  clamp_count
);
   localparam int FRAME_W = $bits(frame_t);
   localparam int PAY_W   = BAUD_W + FRAME_W;

   if (BAUD_W < 1) begin : g_bad_baud
      $error("linecode_clamp: BAUD_W must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("linecode_clamp: CNT_W must lie in 1..32");
   end

   frame_t           req_frame, clamped, out_frame;
   logic             altered;
   logic [PAY_W-1:0] pay_in, pay_out;

   assign req_frame = '{dbits: in_dbits, stop: in_stop, parity: in_parity};

   fclamp_detect i_detect (
      .req_frame     (req_frame),
      .clamped_frame (clamped),
      .altered       (altered)
   );

   assign pay_in = {in_baud, clamped};

   fclamp_slice #(.W(PAY_W)) i_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_valid (in_valid),
      .s_ready (in_ready),
      .s_data  (pay_in),
      .m_valid (out_valid),
      .m_ready (out_ready),
      .m_data  (pay_out)
   );

   assign out_baud   = pay_out[PAY_W-1:FRAME_W];
   assign out_frame  = pay_out[FRAME_W-1:0];
   assign out_dbits  = out_frame.dbits;
   assign out_stop   = out_frame.stop;
   assign out_parity = out_frame.parity;

   fclamp_tally #(.CNT_W(CNT_W)) i_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (in_valid && in_ready && altered),
      .count (clamp_count),
      .warn  (warn_pulse)
   );
endmodule

// File: rtl/linecode_clamp_chk.sv
module linecode_clamp_chk #(
   parameter int BAUD_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [BAUD_W-1:0] in_baud,
   input logic [3:0]        in_dbits,
   input logic [1:0]        in_stop,
   input logic [2:0]        in_parity,
   input logic              out_valid,
   input logic              out_ready,
   input logic [BAUD_W-1:0] out_baud,
   input logic [3:0]        out_dbits,
   input logic [1:0]        out_stop,
   input logic [2:0]        out_parity,
   input logic              warn_pulse,
   input logic [CNT_W-1:0]  clamp_count
);
   localparam logic [CNT_W-1:0] C_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   logic take, take_canon;
   assign take       = in_valid && in_ready;
   assign take_canon = take && in_dbits == 4'd8 && in_stop == 2'd0 && in_parity == 3'd0;

   p_baud_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (out_valid && out_baud == $past(in_baud)));

   p_framing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_dbits == 4'd8 && out_stop == 2'd0 && out_parity == 3'd0));

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clamp_count) |-> clamp_count == $past(clamp_count) + C_ONE);

   p_canon_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take_canon |=> ($stable(clamp_count) && !warn_pulse));

   p_warn_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      warn_pulse |-> clamp_count == C_ONE);

   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clamp_count) == C_MAX |-> clamp_count == C_MAX);

   p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_baud)));
endmodule

bind linecode_clamp linecode_clamp_chk #(.BAUD_W(BAUD_W), .CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_baud(in_baud), .in_dbits(in_dbits), .in_stop(in_stop), .in_parity(in_parity),
   .out_valid(out_valid), .out_ready(out_ready), .out_baud(out_baud),
   .out_dbits(out_dbits), .out_stop(out_stop), .out_parity(out_parity),
   .warn_pulse(warn_pulse), .clamp_count(clamp_count)
);

// File: tb/test_linecode_clamp.sv
`timescale 1ns/1ps
module test_linecode_clamp;
   localparam int BAUD_W = 32;
   localparam int CNT_W  = 4;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid, in_ready, out_valid, out_ready, warn_pulse;
   logic [BAUD_W-1:0] in_baud, out_baud;
   logic [3:0]        in_dbits, out_dbits;
   logic [1:0]        in_stop, out_stop;
   logic [2:0]        in_parity, out_parity;
   logic [CNT_W-1:0]  clamp_count;

   int nchk = 0, nerr = 0, exp_cnt = 0;
   bit warned = 0, done = 0;

   always #2 clk = ~clk;

   linecode_clamp #(.BAUD_W(BAUD_W), .CNT_W(CNT_W)) i_linecode_clamp (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_baud(in_baud), .in_dbits(in_dbits), .in_stop(in_stop), .in_parity(in_parity),
      .out_valid(out_valid), .out_ready(out_ready), .out_baud(out_baud),
      .out_dbits(out_dbits), .out_stop(out_stop), .out_parity(out_parity),
      .warn_pulse(warn_pulse), .clamp_count(clamp_count)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after acceptance
   task automatic send(input int baud, input int d, input int s, input int p);
      bit alt, ew;
      in_baud = baud; in_dbits = d[3:0]; in_stop = s[1:0]; in_parity = p[2:0];
      in_valid = 1'b1;
      #0.1;
      chk(in_ready == 1'b1, "R7 in_ready", in_ready, 1);
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      alt = !(d == 8 && s == 0 && p == 0);
      ew  = alt && !warned;
      if (alt) begin
         warned = 1;
         if (exp_cnt < CMAX) exp_cnt++;
      end
      chk(out_valid == 1'b1, "R7 out_valid", out_valid, 1);
      chk(out_baud == baud, "R1 baud", out_baud, baud);
      chk(out_dbits == 4'd8, "R2 dbits", out_dbits, 8);
      chk(out_stop == 2'd0, "R2 stop", out_stop, 0);
      chk(out_parity == 3'd0, "R2 parity", out_parity, 0);
      if (alt) chk(clamp_count == exp_cnt, "R3/R6 count", clamp_count, exp_cnt);
      else     chk(clamp_count == exp_cnt, "R4 count", clamp_count, exp_cnt);
      chk(warn_pulse == ew, "R5 warn", warn_pulse, ew);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
      chk(clamp_count == 0, "R9 count", clamp_count, 0);
      chk(warn_pulse == 1'b0, "R9 warn", warn_pulse, 0);
      rst_n = 1'b1;
      exp_cnt = 0; warned = 0;
   endtask

   initial begin
      in_valid = 0; in_baud = 0; in_dbits = 0; in_stop = 0; in_parity = 0;
      out_ready = 1'b1;
      do_reset();
      @(negedge clk);
      send(115200, 8, 0, 0);               // R4: canonical first
      for (int d = 0; d < 16; d++)
         for (int s = 0; s < 4; s++)
            for (int p = 0; p < 8; p++)
               send(1000 + d * 97 + s * 13 + p, d, s, p);  // R3, R6 sweep
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R7 idle", out_valid, 0);

      // R8 backpressure
      out_ready = 1'b0;
      send(4800, 5, 2, 1);
      chk(in_ready == 1'b0, "R8 in_ready stall", in_ready, 0);
      in_baud = 9600; in_dbits = 8; in_stop = 0; in_parity = 0; in_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(out_baud == 4800, "R8 hold", out_baud, 4800);
      chk(out_valid == 1'b1, "R8 valid held", out_valid, 1);
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      chk(out_baud == 9600, "R8 pending taken", out_baud, 9600);
      chk(clamp_count == CMAX, "R6 count", clamp_count, CMAX);

      // R5 rearm after a second reset
      do_reset();
      @(negedge clk);
      send(300, 8, 0, 0);
      send(600, 7, 0, 0);
      send(1200, 8, 1, 2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule